// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block is a counting semaphore that several requesters share, for example four processor cores guarding a critical section. Each requester has its own acquire line and release line. The semaphore holds a count of free slots. At reset the count is loaded with the number of holders that may be inside the critical section together. The default of one gives mutual exclusion.

An acquire that finds a free slot takes it and returns a one-cycle grant pulse. An acquire that finds no free slot puts the requester to sleep on a hardware wait list. No grant is returned until a slot is handed to it. A release returns a slot. If anyone is sleeping, the slot goes straight to the oldest sleeper, so no requester has to spin.

Requests are captured per requester. The block then services exactly one of them per cycle, picking among the pending requesters in rotating order. Each read and update of the count is therefore a single indivisible step.

Top module: `csem_core`

## Requirements
- R1: After reset the count `sem_count` equals the parameter `INIT_COUNT` (default 1), and `grant`, `rel_ack` and `sem_err` are all low.
- R2: An acquire serviced while the count is above zero lowers the count by one and pulses that requester's `grant` bit. The pulse and the new count appear on the clock edge after the edge that captured the request.
- R3: An acquire serviced while the count is zero returns no grant, leaves the count at zero and puts the requester to sleep.
- R4: A release serviced while nobody sleeps pulses the releaser's `rel_ack` bit and raises the count by one.
- R5: A release serviced while somebody sleeps pulses the releaser's `rel_ack` bit and, in the same cycle, the `grant` bit of one sleeper. The count is left unchanged, because the woken requester takes the returned slot.
- R6: Sleepers are woken in the order in which they were put to sleep.
- R7: One captured request is serviced per cycle. The choice starts at the requester just after the one serviced last, wrapping from the highest index to index 0. After reset it starts at index 0.
- R8: A release serviced while the count already equals `MAX_COUNT` pulses `sem_err` together with the releaser's `rel_ack` bit, and leaves the count unchanged.
- R9: An acquire or release pulse from a requester that already has a request waiting for service, or that is asleep, is ignored. An acquire and a release raised together by one requester count as a release.
- R10: `grant` and `rel_ack` bits are one-cycle pulses. At most one `grant` bit and at most one `rel_ack` bit are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | NREQ | Acquire request pulse, one bit per requester |
| rel_req | input | NREQ | Release request pulse, one bit per requester |
| grant | output | NREQ | One-cycle grant pulse, one bit per requester |
| rel_ack | output | NREQ | One-cycle release acknowledge, one bit per requester |
| sem_err | output | 1 | One-cycle pulse on a release at the maximum count |
| sem_count | output | clog2(MAX_COUNT+1) | Current number of free slots |

## Verification
Single acquires and releases on an idle semaphore separate the plain decrement and increment paths from the handoff path. With the count at zero, two sleepers are built up and then released one at a time; this separates a direct handoff that keeps the count from a release that counts up. All four requesters acquiring in the same cycle, with only two slots, shows that the rotating start point is used rather than a fixed priority. In that pattern the sleepers join the list in an order that is not index order, so a wake-up in arrival order can be told apart from a lowest-index wake-up. Extra pulses from a sleeping requester, a release at the full count, and an acquire and release raised together cover the ignore and error cases.

// File: rtl/csem_pkg.sv
package csem_pkg;
    // Kind of operation held for a requester while it waits for service.
    typedef enum logic {
        OP_ACQ = 1'b0,
        OP_REL = 1'b1
    } sem_op_e;

    // Width of an index into n entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/csem_rr_pick.sv
module csem_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] pick
);
    // Scan from the highest offset down, so the lowest offset found wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(start) + k) % N;
            if (req[j]) begin
                found = 1'b1;
                pick  = IW'(j);
            end
        end
    end
endmodule

// File: rtl/csem_waitq.sv
module csem_waitq #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_id,
    input  logic          pop,
    output logic          empty,
    output logic [IW-1:0] head_id
);
    localparam int CNTW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0][IW-1:0] slot;
        logic [IW-1:0]        rd;
        logic [IW-1:0]        wr;
        logic [CNTW-1:0]      used;
    } wq_t;

    wq_t wq_d, wq_q;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
        return (int'(p) == N - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wq_d = wq_q;
        if (push) begin
            wq_d.slot[wq_q.wr] = push_id;
            wq_d.wr            = wrap_inc(wq_q.wr);
        end
        if (pop) begin
            wq_d.rd = wrap_inc(wq_q.rd);
        end
        case ({push, pop})
            2'b10:   wq_d.used = wq_q.used + 1'b1;
            2'b01:   wq_d.used = wq_q.used - 1'b1;
            default: wq_d.used = wq_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wq_q <= '0;
        end else begin
            wq_q <= wq_d;
        end
    end

    assign empty   = (wq_q.used == '0);
    assign head_id = wq_q.slot[wq_q.rd];
endmodule

// File: rtl/csem_core.sv
module csem_core
    import csem_pkg::*;
#(
    parameter int NREQ       = 4,
    parameter int INIT_COUNT = 1,
    parameter int MAX_COUNT  = INIT_COUNT
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NREQ-1:0]                  acq_req,
    input  logic [NREQ-1:0]                  rel_req,
    output logic [NREQ-1:0]                  grant,
    output logic [NREQ-1:0]                  rel_ack,
    output logic                             sem_err,
    output logic [$clog2(MAX_COUNT+1)-1:0]   sem_count
);
    localparam int IW = idx_width(NREQ);
    localparam int CW = $clog2(MAX_COUNT + 1);

    typedef struct packed {
        logic [NREQ-1:0] pend;
        logic [NREQ-1:0] pend_rel;
        logic [NREQ-1:0] asleep;
        logic [IW-1:0]   rr;
        logic [CW-1:0]   count;
        logic [NREQ-1:0] grant;
        logic [NREQ-1:0] ack;
        logic            err;
    } sem_t;

    sem_t s_d, s_q;

    logic          sel_found;
    logic [IW-1:0] sel_idx;
    logic          q_push, q_pop, q_empty;
    logic [IW-1:0] q_head;

    csem_rr_pick #(.N(NREQ), .IW(IW)) u_pick (
        .req   (s_q.pend),
        .start (s_q.rr),
        .found (sel_found),
        .pick  (sel_idx)
    );

    csem_waitq #(.N(NREQ), .IW(IW)) u_waitq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .push_id (sel_idx),
        .pop     (q_pop),
        .empty   (q_empty),
        .head_id (q_head)
    );

    always_comb begin
        sem_op_e op;
        s_d       = s_q;
        s_d.grant = '0;
        s_d.ack   = '0;
        s_d.err   = 1'b0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        op        = OP_ACQ;

        // Service one captured request as a single read-modify-write step.
        if (sel_found) begin
            op                = s_q.pend_rel[sel_idx] ? OP_REL : OP_ACQ;
            s_d.pend[sel_idx] = 1'b0;
            s_d.rr            = (int'(sel_idx) == NREQ - 1) ? '0 : sel_idx + 1'b1;
            if (op == OP_REL) begin
                s_d.ack[sel_idx] = 1'b1;
                if (!q_empty) begin
                    // Direct handoff: the returned slot goes to the oldest sleeper.
                    s_d.grant[q_head]  = 1'b1;
                    s_d.asleep[q_head] = 1'b0;
                    q_pop              = 1'b1;
                end else if (s_q.count == CW'(MAX_COUNT)) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.count = s_q.count + 1'b1;
                end
            end else begin
                if (s_q.count != '0) begin
                    s_d.count          = s_q.count - 1'b1;
                    s_d.grant[sel_idx] = 1'b1;
                end else begin
                    s_d.asleep[sel_idx] = 1'b1;
                    q_push              = 1'b1;
                end
            end
        end

        // Capture new requests from requesters that are neither pending nor asleep.
        for (int i = 0; i < NREQ; i++) begin
            if ((acq_req[i] || rel_req[i]) && !s_q.pend[i] && !s_q.asleep[i]) begin
                s_d.pend[i]     = 1'b1;
                s_d.pend_rel[i] = rel_req[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.count <= CW'(INIT_COUNT);
        end else begin
            s_q <= s_d;
        end
    end

    assign grant     = s_q.grant;
    assign rel_ack   = s_q.ack;
    assign sem_err   = s_q.err;
    assign sem_count = s_q.count;
endmodule

// File: rtl/csem_checker.sv
module csem_checker #(
    parameter int NREQ      = 4,
    parameter int MAX_COUNT = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NREQ-1:0]                grant,
    input logic [NREQ-1:0]                rel_ack,
    input logic                           sem_err,
    input logic [$clog2(MAX_COUNT+1)-1:0] sem_count
);
    localparam int CW = $clog2(MAX_COUNT + 1);

    // R10: at most one grant and one acknowledge in any cycle
    p_grant_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_ack));

    // R2: a grant without a release in the same cycle lowers the count by one
    p_acq_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !(|rel_ack)) |-> (sem_count == CW'($past(sem_count) - 1'b1)));

    // R5: a handoff leaves the count unchanged
    p_handoff_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && (|rel_ack)) |-> (sem_count == $past(sem_count)));

    // R8: the error only comes with a release at the full count, which is kept
    p_err_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sem_err |-> ((|rel_ack) && (sem_count == CW'(MAX_COUNT)) && $stable(sem_count)));

    // R4: a release that raises the count comes with no grant
    p_rel_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rel_ack) && !(|grant) && !sem_err) |-> (sem_count == CW'($past(sem_count) + 1'b1)));

    // R8: the count never rises above its maximum
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sem_count <= CW'(MAX_COUNT));
endmodule

bind csem_core csem_checker #(.NREQ(NREQ), .MAX_COUNT(MAX_COUNT)) u_csem_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .rel_ack   (rel_ack),
    .sem_err   (sem_err),
    .sem_count (sem_count)
);

// File: tb/csem_core_bench.sv
`timescale 1ns/1ps
module csem_core_bench;
    localparam int NREQ = 4;
    localparam int INIT = 2;
    localparam int MAXC = 2;
    localparam int CW   = $clog2(MAXC + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] acq_req = '0;
    logic [NREQ-1:0] rel_req = '0;
    logic [NREQ-1:0] grant;
    logic [NREQ-1:0] rel_ack;
    logic            sem_err;
    logic [CW-1:0]   sem_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    is_ack;
        int    id;
        bit    err;
        int    cnt;
        string tag;
    } ev_t;

    ev_t expq[$];

    always #4 clk = ~clk;

    csem_core #(.NREQ(NREQ), .INIT_COUNT(INIT), .MAX_COUNT(MAXC)) u_csem_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_req   (acq_req),
        .rel_req   (rel_req),
        .grant     (grant),
        .rel_ack   (rel_ack),
        .sem_err   (sem_err),
        .sem_count (sem_count)
    );

    task automatic expect_ev(input bit is_ack, input int id, input bit err,
                             input int cnt, input string tag);
        ev_t e;
        e.is_ack = is_ack; e.id = id; e.err = err; e.cnt = cnt; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic pulse(input logic [NREQ-1:0] a, input logic [NREQ-1:0] r, input int gap);
        @(negedge clk);
        acq_req = a;
        rel_req = r;
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per observed acknowledge or grant.
    task automatic observe(input bit is_ack, input int id);
        ev_t e;
        total++;
        if (expq.size() == 0) begin
            bad++;
            $display("FAIL R10: actual=unexpected %s on requester %0d expected=nothing",
                     is_ack ? "ack" : "grant", id);
            return;
        end
        e = expq.pop_front();
        if (e.is_ack != is_ack || e.id != id || e.err != (is_ack && sem_err)
            || e.cnt != int'(sem_count)) begin
            bad++;
            $display("FAIL %s: actual=%s id=%0d err=%0d cnt=%0d expected=%s id=%0d err=%0d cnt=%0d",
                     e.tag, is_ack ? "ack" : "grant", id, is_ack && sem_err, sem_count,
                     e.is_ack ? "ack" : "grant", e.id, e.err, e.cnt);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NREQ; i++) if (rel_ack[i]) observe(1'b1, i);
            for (int i = 0; i < NREQ; i++) if (grant[i]) observe(1'b0, i);
            if (sem_err && rel_ack == '0) begin
                total++; bad++;
                $display("FAIL R8: actual=err without ack expected=err only with ack");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_val("R1 count", int'(sem_count), INIT);
        check_val("R1 outputs", int'({grant, rel_ack, sem_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: plain acquires while slots are free
        expect_ev(0, 0, 0, 1, "R2");
        pulse(4'b0001, 4'b0000, 3);
        expect_ev(0, 1, 0, 0, "R2");
        pulse(4'b0010, 4'b0000, 3);

        // R3: two acquires at zero count go to sleep (2 before 3)
        pulse(4'b1100, 4'b0000, 5);
        check_val("R3 count", int'(sem_count), 0);

        // R5: releases hand slots to sleepers, count kept at zero
        expect_ev(1, 0, 0, 0, "R5");
        expect_ev(0, 2, 0, 0, "R5");
        pulse(4'b0000, 4'b0001, 3);
        expect_ev(1, 1, 0, 0, "R5");
        expect_ev(0, 3, 0, 0, "R6");
        pulse(4'b0000, 4'b0010, 3);

        // R4: releases with no sleepers count up
        expect_ev(1, 2, 0, 1, "R4");
        pulse(4'b0000, 4'b0100, 3);
        expect_ev(1, 3, 0, 2, "R4");
        pulse(4'b0000, 4'b1000, 3);

        // R8: release at the full count
        expect_ev(1, 0, 1, 2, "R8");
        pulse(4'b0000, 4'b0001, 3);

        // R7: all four at once, rotation starts at requester 1
        expect_ev(0, 1, 0, 1, "R7");
        expect_ev(0, 2, 0, 0, "R7");
        pulse(4'b1111, 4'b0000, 6);
        check_val("R7 count", int'(sem_count), 0);

        // R9: extra pulses from sleeping requester 0 are ignored
        pulse(4'b0001, 4'b0000, 3);
        pulse(4'b0000, 4'b0001, 3);
        check_val("R9 count", int'(sem_count), 0);

        // R6: sleepers joined as 3 then 0, so 3 wakes first
        expect_ev(1, 1, 0, 0, "R6");
        expect_ev(0, 3, 0, 0, "R6");
        pulse(4'b0000, 4'b0010, 3);
        expect_ev(1, 2, 0, 0, "R6");
        expect_ev(0, 0, 0, 0, "R6");
        pulse(4'b0000, 4'b0100, 3);
        expect_ev(1, 3, 0, 1, "R4");
        pulse(4'b0000, 4'b1000, 3);
        expect_ev(1, 0, 0, 2, "R4");
        pulse(4'b0000, 4'b0001, 3);

        // R9: acquire and release together count as a release
        expect_ev(1, 1, 1, 2, "R9");
        pulse(4'b0010, 4'b0010, 4);
        check_val("R9 count", int'(sem_count), 2);

        check_val("R10 leftover expected items", expq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule